// File: doc/BRIEF.md
# Interrupt Pending and Enable Controller

This block collects interrupt events from peripheral sources into a pending register and gates them with an enable register. Software reads and writes both registers over a simple memory-mapped bus using either 16-bit or 32-bit accesses. A single CPU interrupt request line is raised whenever any enabled bit is pending.

Acknowledgement is done by writing the pending register: every bit written as 0 is cleared, and every bit that is disabled in the enable register at that moment is cleared as well. Some sources are level sensitive (by default bits 7 and 9). If such a source is still asserted when an acknowledge write happens, its bit is set again before the write is applied, so a held condition cannot be lost. Writing the enable register stores the new value. If the pending bits then meet the new enables, a one-cycle re-check event is emitted for the CPU side. A 16-bit access reaches only bits 15:0 of a register.

Top module: `irq_stat_mask_ctrl`

## Requirements
- R1: After reset the pending and enable registers read 0, and `irq_req` and `recheck_evt` are 0.
- R2: A 1 on `src_set[i]` for one cycle sets pending bit i at the next clock edge. The bit stays set until it is acknowledged.
- R3: A 32-bit write to offset 0x070 makes the pending register equal to (old pending OR held level sources) AND enable AND written data. A bit written 0 clears, and a disabled bit clears even when it is written 1.
- R4: A 16-bit write (`bus_size`=0) to offset 0x070 applies the R3 rule to bits 15:0 only. Bits 31:16 keep their value.
- R5: On a write to offset 0x070, bits in the level set (default bits 7 and 9) whose `src_level` input is high are set again before the R3 rule is applied. Such a bit survives the write when it is enabled and written 1.
- R6: A `src_set` pulse in the same cycle as an acknowledge write wins, and the bit ends set.
- R7: A 32-bit write to offset 0x074 replaces the enable register. A 16-bit write to 0x074 replaces bits 15:0 and keeps bits 31:16.
- R8: A write to 0x074 pulses `recheck_evt` high for exactly one cycle after the edge that stores it, if and only if the pending value before that edge ANDed with the new enable value is nonzero. Otherwise `recheck_evt` stays 0.
- R9: `irq_req` is a register. After every edge it equals the OR of (pending AND enable) as they stand after that edge.
- R10: A read of 0x070 or 0x074 returns the register in the same cycle on `bus_rdata`. A 16-bit read returns bits 15:0 with zeros above them. A read of any other offset returns 0, and a write to any other offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Bus access valid this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 1 | 1 = 32-bit access, 0 = 16-bit access (bits 15:0) |
| bus_addr | input | ADDR_W | Byte offset inside the I/O page |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| src_set | input | DATA_W | One-cycle set pulses, one per pending bit |
| src_level | input | DATA_W | Held state of level-type sources |
| irq_req | output | 1 | Registered interrupt request |
| recheck_evt | output | 1 | One-cycle pulse after an enable write that finds pending work |

## Verification
The hardest situations to reach from the ports are an acknowledge write that lands in the same cycle as a set pulse, and one that lands while a level source is still high. The random stimulus sparsifies set pulses by ANDing several draws, so collisions occur but do not saturate the register. It also drives the level bits independently of the writes. Directed sequences cover the exact collision, a 16-bit acknowledge that must leave upper bits alone, and an enable write that does or does not find pending bits.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  typedef enum logic {
    SZ_HALF = 1'b0,
    SZ_WORD = 1'b1
  } bus_size_e;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_MASK   = 2'd2
  } reg_sel_e;

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] STAT_OFS = 12'h070,
  parameter logic [ADDR_W-1:0] MASK_OFS = 12'h074
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  output reg_sel_e          sel,
  output logic              wr_stat,
  output logic              wr_mask,
  output logic [DATA_W-1:0] lanes
);

  localparam int unsigned HALF_W = DATA_W / 2;

  bus_size_e size_e;

  always_comb begin
    size_e = bus_size_e'(bus_size);
    if (bus_addr == STAT_OFS) begin
      sel = SEL_STATUS;
    end else if (bus_addr == MASK_OFS) begin
      sel = SEL_MASK;
    end else begin
      sel = SEL_NONE;
    end
    wr_stat = bus_valid && bus_write && (sel == SEL_STATUS);
    wr_mask = bus_valid && bus_write && (sel == SEL_MASK);
  end

  // Per-bit lane enable: the lower half is always reachable, the upper half only by word access
  for (genvar b = 0; b < DATA_W; b++) begin : g_lane
    if (b < HALF_W) begin : g_low
      assign lanes[b] = 1'b1;
    end else begin : g_high
      assign lanes[b] = (size_e == SZ_WORD);
    end
  end

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] LEVEL_MASK = 32'h0000_0280
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] lanes,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] mask_q,
  input  logic [DATA_W-1:0] src_set,
  input  logic [DATA_W-1:0] src_level,
  output logic [DATA_W-1:0] status_q,
  output logic [DATA_W-1:0] status_d
);

  logic [DATA_W-1:0] reasserted;
  logic [DATA_W-1:0] acked;
  logic [DATA_W-1:0] kept;

  always_comb begin
    // held level sources are set again before the acknowledge is applied
    reasserted = status_q | (src_level & LEVEL_MASK);
    acked      = reasserted & mask_q & wdata;
    if (wr_en) begin
      kept = (acked & lanes) | (status_q & ~lanes);
    end else begin
      kept = status_q;
    end
    // new events win over a clear in the same cycle
    status_d = kept | src_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else begin
      status_q <= status_d;
    end
  end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] lanes,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] mask_d
);

  always_comb begin
    if (wr_en) begin
      mask_d = (mask_q & ~lanes) | (wdata & lanes);
    end else begin
      mask_d = mask_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (wr_en) begin
      mask_q <= mask_d;
    end
  end

endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_wr,
  input  logic [DATA_W-1:0] status_q,
  input  logic [DATA_W-1:0] status_d,
  input  logic [DATA_W-1:0] mask_d,
  output logic              irq_req,
  output logic              recheck_evt
);

  logic irq_d;
  logic evt_d;

  always_comb begin
    irq_d = |(status_d & mask_d);
    // the re-check uses the pending value seen by the enable write itself
    evt_d = mask_wr && (|(status_q & mask_d));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req     <= 1'b0;
      recheck_evt <= 1'b0;
    end else begin
      irq_req     <= irq_d;
      recheck_evt <= evt_d;
    end
  end

endmodule

// File: rtl/irq_stat_mask_ctrl.sv
module irq_stat_mask_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] STAT_OFS = 12'h070,
  parameter logic [ADDR_W-1:0] MASK_OFS = 12'h074,
  parameter logic [DATA_W-1:0] LEVEL_MASK = 32'h0000_0280
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] src_set,
  input  logic [DATA_W-1:0] src_level,
  output logic              irq_req,
  output logic              recheck_evt
);

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  reg_sel_e          sel;
  logic              wr_stat;
  logic              wr_mask;
  logic [DATA_W-1:0] lanes;
  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] status_d;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] mask_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  irq_bus_decode #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .STAT_OFS(STAT_OFS),
    .MASK_OFS(MASK_OFS)
  ) u_dec (
    .bus_valid(bus_valid),
    .bus_write(bus_write),
    .bus_size (bus_size),
    .bus_addr (bus_addr),
    .sel      (sel),
    .wr_stat  (wr_stat),
    .wr_mask  (wr_mask),
    .lanes    (lanes)
  );

  irq_status_reg #(
    .DATA_W    (DATA_W),
    .LEVEL_MASK(LEVEL_MASK)
  ) u_stat (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_stat),
    .lanes    (lanes),
    .wdata    (bus_wdata),
    .mask_q   (mask_q),
    .src_set  (src_set),
    .src_level(src_level),
    .status_q (status_q),
    .status_d (status_d)
  );

  irq_mask_reg #(
    .DATA_W(DATA_W)
  ) u_mask (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (wr_mask),
    .lanes (lanes),
    .wdata (bus_wdata),
    .mask_q(mask_q),
    .mask_d(mask_d)
  );

  irq_req_gen #(
    .DATA_W(DATA_W)
  ) u_req (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .mask_wr    (wr_mask),
    .status_q   (status_q),
    .status_d   (status_d),
    .mask_d     (mask_d),
    .irq_req    (irq_req),
    .recheck_evt(recheck_evt)
  );

  // combinational read path, narrowed by the access lanes
  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      case (sel)
        SEL_STATUS: bus_rdata = status_q & lanes;
        SEL_MASK:   bus_rdata = mask_q & lanes;
        default:    bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] STAT_OFS = 12'h070,
  parameter logic [ADDR_W-1:0] MASK_OFS = 12'h074
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic              bus_size,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] src_set,
  input logic [DATA_W-1:0] status_q,
  input logic [DATA_W-1:0] mask_q,
  input logic              irq_req,
  input logic              recheck_evt
);

  logic stat_wr_seen;
  logic mask_wr_seen;

  assign stat_wr_seen = bus_valid && bus_write && (bus_addr == STAT_OFS);
  assign mask_wr_seen = bus_valid && bus_write && (bus_addr == MASK_OFS);

  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == (|(status_q & mask_q))); // R9

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(src_set)) == $past(src_set))); // R6

  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_wr_seen && (src_set == '0)) |=> $stable(status_q)); // R2

  AST_ACK_DROPS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr_seen && bus_size && (src_set == '0)) |=> ((status_q & ~$past(mask_q)) == '0)); // R3

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr_seen |=> $stable(mask_q)); // R7

  AST_EVT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    recheck_evt |-> $past(mask_wr_seen)); // R8

endmodule

bind irq_stat_mask_ctrl irq_ctrl_checker #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .STAT_OFS(STAT_OFS),
  .MASK_OFS(MASK_OFS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .bus_size   (bus_size),
  .bus_addr   (bus_addr),
  .src_set    (src_set),
  .status_q   (status_q),
  .mask_q     (mask_q),
  .irq_req    (irq_req),
  .recheck_evt(recheck_evt)
);

// File: tb/tb_irq_stat_mask_ctrl.sv
`timescale 1ns/1ps
module tb_irq_stat_mask_ctrl;

  localparam int unsigned AW = 12;
  localparam int unsigned DW = 32;
  localparam logic [31:0] LVL = 32'h0000_0280;
  localparam logic [11:0] A_ST = 12'h070;
  localparam logic [11:0] A_MK = 12'h074;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_valid, bus_write, bus_size;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata, src_set, src_level;
  logic          irq_req, recheck_evt;

  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;
  logic [31:0] m_stat, m_mask;

  always #4 clk = ~clk;

  irq_stat_mask_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .src_set(src_set), .src_level(src_level),
    .irq_req(irq_req), .recheck_evt(recheck_evt)
  );

  function automatic logic [31:0] lanes_of(input logic sz);
    return sz ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a, input logic sz);
    if (a == A_ST) return m_stat & lanes_of(sz);
    if (a == A_MK) return m_mask & lanes_of(sz);
    return 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // one bus cycle; called just after a falling edge
  task automatic op(input logic v, input logic w, input logic sz, input logic [11:0] a,
                    input logic [31:0] wd, input logic [31:0] set, input logic [31:0] lvl,
                    input string tag);
    logic [31:0] ln, ns, nm;
    logic ev;
    bus_valid = v; bus_write = w; bus_size = sz; bus_addr = a;
    bus_wdata = wd; src_set = set; src_level = lvl;
    #1;
    if (v && !w) check({tag, " read"}, bus_rdata, exp_read(a, sz));
    ln = lanes_of(sz);
    ns = m_stat; nm = m_mask; ev = 1'b0;
    if (v && w && a == A_ST)
      ns = ((((m_stat | (lvl & LVL)) & m_mask & wd)) & ln) | (m_stat & ~ln);
    ns = ns | set;
    if (v && w && a == A_MK) begin
      nm = (m_mask & ~ln) | (wd & ln);
      ev = |(m_stat & nm);
    end
    @(posedge clk);
    @(negedge clk);
    m_stat = ns; m_mask = nm;
    check("R9 irq_req", {31'h0, irq_req}, {31'h0, |(ns & nm)});
    check("R8 recheck_evt", {31'h0, recheck_evt}, {31'h0, ev});
  endtask

  task automatic idle();
    op(1'b0, 1'b0, 1'b1, 12'h0, 32'h0, 32'h0, 32'h0, "idle");
  endtask

  task automatic rd(input logic [11:0] a, input logic sz, input string tag);
    op(1'b1, 1'b0, sz, a, 32'h0, 32'h0, 32'h0, tag);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd7321);
    m_stat = '0; m_mask = '0;
    rst_n = 1'b0; bus_valid = 0; bus_write = 0; bus_size = 1; bus_addr = '0;
    bus_wdata = '0; src_set = '0; src_level = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 irq_req", {31'h0, irq_req}, 32'h0);
    check("R1 recheck_evt", {31'h0, recheck_evt}, 32'h0);
    rd(A_ST, 1'b1, "R1 status");
    rd(A_MK, 1'b1, "R1 mask");

    // R2 set pulse with enables off: pending but no request
    op(0, 0, 1, 12'h0, 32'h0, 32'h0000_0008, 32'h0, "R2 set");
    idle();
    rd(A_ST, 1'b1, "R2 status held");

    // R8 enable write finding pending work, then one without
    op(1, 1, 1, A_MK, 32'h0000_0008, 32'h0, 32'h0, "R8 mask hit");
    op(1, 1, 1, A_MK, 32'h0000_0009, 32'h0, 32'h0, "R8 mask hit again");
    op(1, 1, 1, A_MK, 32'h0000_0001, 32'h0, 32'h0, "R8 mask miss");
    rd(A_MK, 1'b1, "R7 mask 32");

    // R3 masked-off bit drops even when written 1; enabled bit written 1 survives
    op(0, 0, 1, 12'h0, 32'h0, 32'h0000_0003, 32'h0, "R3 set");
    op(1, 1, 1, A_ST, 32'hFFFF_FFFF, 32'h0, 32'h0, "R3 ack ones");
    rd(A_ST, 1'b1, "R3 masked cleared");
    op(1, 1, 1, A_ST, 32'hFFFF_FFFE, 32'h0, 32'h0, "R3 ack zero");
    rd(A_ST, 1'b1, "R3 zero cleared");

    // R5 level source held during acknowledge
    op(1, 1, 1, A_MK, 32'h0000_0280, 32'h0, 32'h0, "R5 mask");
    op(1, 1, 1, A_ST, 32'hFFFF_FFFF, 32'h0, 32'h0000_0080, "R5 ack level");
    rd(A_ST, 1'b1, "R5 level reset");
    op(1, 1, 1, A_ST, 32'hFFFF_FFFF, 32'h0, 32'h0000_0001, "R5 non-level");
    rd(A_ST, 1'b1, "R5 non-level ignored");

    // R6 set and clear collide
    op(1, 1, 1, A_ST, 32'h0, 32'h0000_0200, 32'h0, "R6 collide");
    rd(A_ST, 1'b1, "R6 set wins");

    // R4 half-word acknowledge keeps the upper half
    op(0, 0, 1, 12'h0, 32'h0, 32'h0010_0000, 32'h0, "R4 set high");
    op(1, 1, 0, A_ST, 32'h0, 32'h0, 32'h0, "R4 ack half");
    rd(A_ST, 1'b1, "R4 upper kept");
    rd(A_ST, 1'b0, "R10 half read");

    // R7 half-word enable write keeps the upper half
    op(1, 1, 1, A_MK, 32'hA500_0000, 32'h0, 32'h0, "R7 mask set high");
    op(1, 1, 0, A_MK, 32'hFFFF_1234, 32'h0, 32'h0, "R7 mask half");
    rd(A_MK, 1'b1, "R7 mask upper kept");

    // R10 unmapped offsets
    op(1, 1, 1, 12'h100, 32'hFFFF_FFFF, 32'h0, 32'h0, "R10 stray write");
    op(1, 1, 1, 12'h072, 32'hFFFF_FFFF, 32'h0, 32'h0, "R10 stray write 2");
    rd(A_MK, 1'b1, "R10 mask untouched");
    rd(A_ST, 1'b1, "R10 status untouched");
    rd(12'h100, 1'b1, "R10 stray read");

    // random mix
    for (int i = 0; i < 800; i++) begin
      logic [31:0] r;
      logic [11:0] a;
      r = $urandom;
      case (r[1:0])
        2'd0: a = A_ST;
        2'd1: a = A_MK;
        2'd2: a = (r[2] ? A_ST : A_MK);
        default: a = (r[3] ? 12'h072 : 12'h100);
      endcase
      op(r[4], r[5], r[6], a, (r[7] ? $urandom : ~32'h0),
         ($urandom & $urandom & $urandom), ({$urandom} & LVL), "R3 random");
      if (r[11:8] == 4'h0) rd(A_ST, 1'b1, "R3 random status");
      if (r[11:8] == 4'h1) rd(A_MK, 1'b1, "R7 random mask");
    end
    rd(A_ST, 1'b1, "R3 final status");
    rd(A_MK, 1'b1, "R7 final mask");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule